// File: doc/BRIEF.md
# Fan Tachometer Period Capture

This block measures the time between two tachometer pulses from a cooling fan when software asks for it. Software writes a start command to the control register. The block then waits for a rising edge on the tachometer line and counts system clock cycles up to the next rising edge. It stores that count in a result register and raises a level interrupt. The interrupt stays high until software writes an acknowledge code. Each start command yields at most one measurement.

Software converts the count to speed as 60 × f_clk / (pulses_per_rev × count), where a fan gives 1, 2 or 4 pulses per revolution. A stalled fan never produces the second edge, so the block never reports completion, and software falls back to zero speed after its own timeout. The tachometer input is asynchronous. It passes through a flop synchroniser, and the block detects rising edges only after that synchroniser. The count saturates at all-ones and does not wrap.

Top module: `fan_tach_capture`

## Requirements
- R1: After reset the control register (offset 0x0) reads 0, the result register (offset 0x4) reads 0 and `irq_o` is low.
- R2: A write to offset 0x0 with bit 0 set and bit 2 clear arms a measurement. While the measurement runs, the control register reads 0x1 (bit 0 = armed, bit 1 = done).
- R3: The result register holds, zero-extended, the number of clock cycles between the first and the second synchronised rising tachometer edge after arming. A tachometer period of P cycles gives P.
- R4: When the second edge arrives, the control register reads 0x3 and `irq_o` goes high. Both hold until an acknowledge or a new start.
- R5: A write to offset 0x0 with bit 2 set (for example 0x5) acknowledges. The next cycle the control register reads 0, `irq_o` is low and any running measurement is abandoned. The result register keeps its value.
- R6: If no second rising edge arrives, the done bit and `irq_o` never assert, however long the wait.
- R7: The cycle count saturates at 2^CNT_W − 1. Longer intervals report that value and do not wrap.
- R8: A start write during a measurement, or while a result is pending, restarts the block. It clears done and `irq_o`, and it hunts again for a first edge.
- R9: Tachometer edges while the block is not armed change neither the result register nor `irq_o`.
- R10: Writes to offset 0x4 are ignored. The result register reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the unit of the measured count |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | ADDR_W | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tach_i | input | 1 | Asynchronous tachometer pulse input |
| irq_o | output | 1 | Level interrupt, high while a result is pending |

## Verification
A sequencer stuck in its hunt or timing state shows at the ports as a control register frozen at 0x1 and an interrupt that never rises. An off-by-one or a wrong edge choice in the counter shows as a result value that is wrong at the first completion, within two tachometer periods of arming. Restart and abort faults show one cycle after the offending write, as a wrong control value or a stale interrupt. Saturation faults show as a small, wrapped result for an interval longer than the counter range.

// File: rtl/fan_tach_pkg.sv
// Package: fan_tach_pkg
// Shared register offsets, control bit positions and the sequencer state
// type for the tachometer period capture block.
package fan_tach_pkg;

    localparam int BUS_W       = 32;
    localparam int OFS_CTRL    = 'h0;
    localparam int OFS_RESULT  = 'h4;

    // Control register bit positions (software depends on these)
    localparam int CTRL_ARMED  = 0;   // write: start, read: armed
    localparam int CTRL_DONE   = 1;   // read: result pending
    localparam int CTRL_ACK    = 2;   // write: acknowledge / abort

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // nothing requested
        ST_HUNT = 2'd1,   // armed, waiting for the first edge
        ST_TIME = 2'd2,   // counting towards the second edge
        ST_DONE = 2'd3    // result latched, interrupt pending
    } meas_state_t;

endpackage

// File: rtl/tach_edge_detect.sv
// Module: tach_edge_detect
// Brings the asynchronous tachometer input into the clock domain through a
// chain of SYNC_STAGES flops and flags each rising edge of the synchronised
// signal with a one-cycle pulse.
// Assumes: tachometer pulses last longer than two clock cycles.
module tach_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tach_async,
    output logic rise_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Synchroniser chain; stage 0 samples the raw pin
    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= tach_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // Previous synchronised level, for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    assign rise_o = sync_q[SYNC_STAGES-1] & ~last_q;

    AST_RISE_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R3

endmodule

// File: rtl/tach_period_counter.sv
// Module: tach_period_counter
// Single-shot sequencer: on start it hunts for a rising edge, counts clock
// cycles up to the next rising edge and latches the saturated count.
// Assumes: start and abort are one-cycle pulses; abort wins over start.
module tach_period_counter
    import fan_tach_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             abort_i,
    input  logic             rise_i,
    output logic             armed_o,
    output logic             done_o,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    meas_state_t      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] result_q;

    // Saturating increment of the running count
    always_comb begin
        cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
    end

    // Sequencer, running counter and result latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            result_q <= '0;
        end else if (abort_i) begin
            state_q  <= ST_IDLE;
        end else if (start_i) begin
            state_q  <= ST_HUNT;
            cnt_q    <= '0;
        end else begin
            case (state_q)
                ST_HUNT: begin
                    if (rise_i) begin
                        state_q <= ST_TIME;
                        cnt_q   <= '0;
                    end
                end
                ST_TIME: begin
                    if (rise_i) begin
                        result_q <= cnt_inc;
                        state_q  <= ST_DONE;
                    end else begin
                        cnt_q    <= cnt_inc;
                    end
                end
                default: begin
                    state_q <= state_q;
                end
            endcase
        end
    end

    assign armed_o = (state_q != ST_IDLE);
    assign done_o  = (state_q == ST_DONE);
    assign count_o = result_q;

    AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !abort_i) |=> (armed_o && !done_o)); // R8
    AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!armed_o && !done_o)); // R5
    AST_DONE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(rise_i)); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TIME && cnt_q == CNT_MAX && !start_i && !abort_i)
        |=> (state_q != ST_TIME || cnt_q == CNT_MAX)); // R7
    AST_RESULT_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count_o) |-> $rose(done_o)); // R9

endmodule

// File: rtl/tach_regs.sv
// Module: tach_regs
// Register decode: turns control writes into start/abort pulses and muxes
// the control and result registers onto the read bus.
// Assumes: reads are combinational; unused offsets read zero.
module tach_regs
    import fan_tach_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BUS_W-1:0] wdata_i,
    input  logic             armed_i,
    input  logic             done_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             start_o,
    output logic             abort_o,
    output logic [BUS_W-1:0] rdata_o
);

    logic ctrl_sel;
    logic unused_wdata;

    assign ctrl_sel     = (addr_i == ADDR_W'(OFS_CTRL));
    assign unused_wdata = ^{wdata_i[BUS_W-1:CTRL_ACK+1], wdata_i[CTRL_DONE]};

    // Command decode: acknowledge takes priority over start
    always_comb begin
        abort_o = wr_i && ctrl_sel && wdata_i[CTRL_ACK];
        start_o = wr_i && ctrl_sel && wdata_i[CTRL_ARMED] && !wdata_i[CTRL_ACK];
    end

    // Read mux
    always_comb begin
        rdata_o = '0;
        if (ctrl_sel) begin
            rdata_o[CTRL_ARMED] = armed_i;
            rdata_o[CTRL_DONE]  = done_i;
        end else if (addr_i == ADDR_W'(OFS_RESULT)) begin
            rdata_o = BUS_W'(count_i);
        end
    end

    AST_DONE_WITH_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> armed_i); // R4
    AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && abort_o)); // R5

endmodule

// File: rtl/fan_tach_capture.sv
// Module: fan_tach_capture
// Top of the tachometer period capture block: synchroniser and edge
// detector, single-shot period counter and register decode.
// Assumes: CNT_W does not exceed the 32-bit register width.
module fan_tach_capture
    import fan_tach_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              tach_i,
    output logic              irq_o
);

    logic             rise;
    logic             start;
    logic             abort;
    logic             armed;
    logic             done;
    logic [CNT_W-1:0] count;

    tach_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .tach_async (tach_i),
        .rise_o     (rise)
    );

    tach_period_counter #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .abort_i (abort),
        .rise_i  (rise),
        .armed_o (armed),
        .done_o  (done),
        .count_o (count)
    );

    tach_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .armed_i (armed),
        .done_i  (done),
        .count_i (count),
        .start_o (start),
        .abort_o (abort),
        .rdata_o (reg_rdata)
    );

    assign irq_o = done;

    AST_IRQ_CLEARED_BY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(OFS_CTRL) && reg_wdata[CTRL_ACK])
        |=> !irq_o); // R5

endmodule

// File: tb/fan_tach_capture_test.sv
module fan_tach_capture_test;

    localparam int CNT_W = 10;
    localparam int SAT   = (1 << CNT_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h4;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tach_i = 1'b0;
    logic        irq_o;

    int errors = 0;
    int checks = 0;
    int exp_q[$];
    logic irq_prev = 1'b0;

    always #5 clk = ~clk;

    fan_tach_capture #(.ADDR_W(4), .CNT_W(CNT_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tach_i    (tach_i),
        .irq_o     (irq_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 4'h4; reg_wdata = '0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = 4'h4;
    endtask

    task automatic tach_wave(input int period, input int high, input int n);
        for (int i = 0; i < n; i++) begin
            tach_i = 1'b1;
            repeat (high) @(negedge clk);
            tach_i = 1'b0;
            repeat (period - high) @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: each rising interrupt must match the next expected count (R3, R4)
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (irq_o && !irq_prev) begin
                if (exp_q.size() == 0) begin
                    check("R6 unexpected completion", 1, 0);
                end else begin
                    check("R3 measured count", reg_rdata, exp_q.pop_front());
                end
            end
            irq_prev = irq_o;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        idle(4);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        bus_read(4'h0, rd); check("R1 ctrl after reset", rd, 0);
        bus_read(4'h4, rd); check("R1 result after reset", rd, 0);
        check("R1 irq after reset", irq_o, 0);

        // R2 arm, R3/R4 period 37
        bus_write(4'h0, 32'h1);
        bus_read(4'h0, rd); check("R2 ctrl while measuring", rd, 1);
        exp_q.push_back(37);
        tach_wave(37, 10, 3);
        idle(4);
        bus_read(4'h0, rd); check("R4 ctrl when done", rd, 3);
        check("R4 irq when done", irq_o, 1);

        // R5 acknowledge
        bus_write(4'h0, 32'h5);
        check("R5 irq after ack", irq_o, 0);
        bus_read(4'h0, rd); check("R5 ctrl after ack", rd, 0);
        bus_read(4'h4, rd); check("R5 result kept", rd, 37);

        // R9 edges while idle
        tach_wave(20, 5, 3);
        idle(4);
        bus_read(4'h4, rd); check("R9 result after idle edges", rd, 37);
        check("R9 irq after idle edges", irq_o, 0);

        // R10 write to result ignored
        bus_write(4'h4, 32'hABC);
        bus_read(4'h4, rd); check("R10 result after write", rd, 37);

        // R3 short period
        bus_write(4'h0, 32'h1);
        exp_q.push_back(5);
        tach_wave(5, 2, 3);
        idle(4);
        bus_write(4'h0, 32'h5);

        // R8 restart during measurement
        bus_write(4'h0, 32'h1);
        tach_wave(20, 10, 1);
        bus_write(4'h0, 32'h1);
        bus_read(4'h0, rd); check("R8 ctrl after restart", rd, 1);
        exp_q.push_back(30);
        tach_wave(30, 12, 3);
        idle(4);
        bus_read(4'h4, rd); check("R8 result after restart", rd, 30);

        // R8 start while result pending
        bus_write(4'h0, 32'h1);
        check("R8 irq cleared by start", irq_o, 0);
        bus_read(4'h0, rd); check("R8 ctrl rearmed", rd, 1);
        exp_q.push_back(12);
        tach_wave(12, 4, 3);
        idle(4);
        bus_write(4'h0, 32'h5);

        // R6 stalled fan: no edge, then a single edge held high
        bus_write(4'h0, 32'h1);
        idle(1500);
        check("R6 irq with no edges", irq_o, 0);
        tach_i = 1'b1;
        idle(1500);
        check("R6 irq after one edge", irq_o, 0);
        bus_read(4'h0, rd); check("R6 ctrl still armed", rd, 1);
        tach_i = 1'b0;
        bus_write(4'h0, 32'h5);

        // R5 abort mid-measurement
        bus_write(4'h0, 32'h1);
        tach_wave(20, 8, 1);
        bus_write(4'h0, 32'h5);
        tach_wave(20, 8, 3);
        idle(4);
        check("R5 irq after abort", irq_o, 0);
        bus_read(4'h4, rd); check("R5 result after abort", rd, 12);

        // R7 saturation boundary
        bus_write(4'h0, 32'h1);
        exp_q.push_back(SAT - 1);
        tach_wave(SAT - 1, 50, 3);
        idle(4);
        bus_write(4'h0, 32'h5);
        bus_write(4'h0, 32'h1);
        exp_q.push_back(SAT);
        tach_wave(SAT, 50, 3);
        idle(4);
        bus_write(4'h0, 32'h5);
        bus_write(4'h0, 32'h1);
        exp_q.push_back(SAT);
        tach_wave(SAT + 1, 50, 2);
        idle(4);
        bus_write(4'h0, 32'h5);
        bus_write(4'h0, 32'h1);
        exp_q.push_back(SAT);
        tach_wave(1500, 100, 2);
        idle(4);
        bus_read(4'h4, rd); check("R7 saturated result", rd, SAT);
        bus_write(4'h0, 32'h5);

        idle(4);
        check("R3 all expected results seen", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule